// File: doc/BRIEF.md
# Stretched Single-Bit Clock-Domain Transfer

This block moves a stream of single-bit event values from one clock domain into another clock domain that has no fixed phase relation to it. On the source side a registered copy of the input bit is the only signal that crosses. Whenever that copy takes a new value, a down-counter keeps it frozen for a fixed number of source cycles. The destination clock can be slower than the source clock, and this hold makes sure the destination still samples every value. While the counter runs, the source reports itself busy and does not take any new input values.

The hold length comes from the two clock periods, which are given as parameters in picoseconds. It is two destination periods expressed in source cycles and rounded to the nearest whole number, with a floor of one. On the destination side the crossing bit enters a single resynchronizing chain of at least two flops, with no logic between the stages. The output of the last stage is the result in the destination domain. Each domain has its own synchronous active-low reset.

Top module: `stretch_bit_cdc`

## Requirements
- R1: The source hold length is round(2 × DST_PERIOD_PS / SRC_PERIOD_PS) source cycles, never less than 1. With the default periods of 5000 ps and 13700 ps this gives 5.
- R2: When the source is idle (busy low) and `src_bit_i` differs from the held value, the held value takes `src_bit_i` at the next source clock edge.
- R3: After a new value is taken, `src_busy_o` is high for exactly hold − 1 source cycles and then returns low. With a hold of 1 it never rises.
- R4: While `src_busy_o` is high, changes on `src_bit_i` are ignored. The held value stays unchanged, and an ignored value never appears at `dst_bit_o`.
- R5: An input equal to the held value starts no hold, so `src_busy_o` stays low.
- R6: `dst_bit_o` shows every value taken by the source, in the same order, with no lost and no extra transitions. Each value reaches the output through SYNC_STAGES destination flops.
- R7: A low `src_rst_n` at a source clock edge clears the held value and the counter, so the source is idle with a held value of 0.
- R8: A low `dst_rst_n` at a destination clock edge clears the whole resynchronizing chain, so `dst_bit_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain synchronous reset, active low |
| src_bit_i | input | 1 | Event value offered in the source domain |
| src_busy_o | output | 1 | High while a taken value is still being held; input is ignored |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain synchronous reset, active low |
| dst_bit_o | output | 1 | Resynchronized value in the destination domain |

## Verification
Two functions can fall in the same source cycle: the hold counter reaching its end, and a pending input change that is waiting to be taken. The bench provokes this by toggling the input every cycle and by toggling it exactly once per hold length, so that a differing value is present on the very edge where the source becomes idle again. A behavioural model judges the outcome. It expects the value to be taken on the first idle edge and never earlier, and it compares `src_busy_o` on every source cycle. In the destination domain, every transition of `dst_bit_o` is matched against a queue of the values the model says were taken.

// File: rtl/stretch_cdc_pkg.sv
// stretch_cdc_pkg
// Shared helpers for the stretched single-bit crossing.
// Assumes both clock periods are given in picoseconds as positive integers.
package stretch_cdc_pkg;

    // Hold length in source cycles: two destination periods, rounded, at least 1.
    function automatic int unsigned hold_from_periods(input int unsigned src_ps,
                                                      input int unsigned dst_ps);
        int unsigned h;
        h = (2 * dst_ps + src_ps / 2) / src_ps;
        return (h < 1) ? 1 : h;
    endfunction

    // Counter width able to hold the value (hold - 1), at least one bit.
    function automatic int unsigned count_width(input int unsigned hold);
        return (hold > 2) ? $clog2(hold) : 1;
    endfunction

endpackage

// File: rtl/stretch_launch.sv
// stretch_launch
// Source-domain launch register with a hold counter. A differing input is
// taken only while idle, then frozen for HOLD_CYCLES source cycles in total.
// Assumes HOLD_CYCLES >= 1; launch_o is a plain flop output so that nothing
// combinational sits in front of the crossing.
module stretch_launch #(
    parameter int unsigned HOLD_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic busy_o,
    output logic launch_o
);
    import stretch_cdc_pkg::*;

    localparam int unsigned CNT_W = count_width(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             launch_q;
    logic             idle;
    logic             take;

    // Idle when the counter has run out; take only a differing value.
    always_comb begin
        idle = (cnt_q == '0);
        take = idle && (bit_i != launch_q);
    end

    // Load a new value and start the hold, or count the hold down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            launch_q <= 1'b0;
        end else if (take) begin
            launch_q <= bit_i;
            cnt_q    <= RELOAD;
        end else if (!idle) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign busy_o   = !idle;
    assign launch_o = launch_q;

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(launch_o));

    // R2
    idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (bit_i != launch_o)) |=> (launch_o == $past(bit_i)));

    // R3
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(launch_o) |-> ((HOLD_CYCLES == 1) || busy_o));

    // R7
    src_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !launch_o));

endmodule

// File: rtl/bit_sync_chain.sv
// bit_sync_chain
// Destination-domain resynchronizer: STAGES flops in series with nothing
// between them. Assumes STAGES >= 2 and that din comes straight from a flop
// of another domain and feeds no other synchronizer.
module bit_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the foreign-domain bit.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                // Later stages give a possibly unsettled value a full cycle to resolve.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    // R8
    dst_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == 1'b0));

endmodule

// File: rtl/stretch_bit_cdc.sv
// stretch_bit_cdc
// Top of the stretched single-bit crossing: a source launch register with a
// period-derived hold, and one resynchronizing chain in the destination.
// Assumes the two clocks are unrelated and the periods below match them.
module stretch_bit_cdc #(
    parameter int unsigned SRC_PERIOD_PS = 5000,
    parameter int unsigned DST_PERIOD_PS = 13700,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_bit_i,
    output logic src_busy_o,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_bit_o
);
    import stretch_cdc_pkg::*;

    localparam int unsigned HOLD_CYCLES = hold_from_periods(SRC_PERIOD_PS, DST_PERIOD_PS);

    logic cross_bit;

    stretch_launch #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_launch (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .bit_i    (src_bit_i),
        .busy_o   (src_busy_o),
        .launch_o (cross_bit)
    );

    bit_sync_chain #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .din   (cross_bit),
        .dout  (dst_bit_o)
    );

endmodule

// File: tb/stretch_bit_cdc_bench.sv
`timescale 1ns/1ps
module stretch_bit_cdc_bench;
    localparam int SRC_PS   = 5000;
    localparam int DST_PS   = 13700;
    localparam int STAGES   = 2;
    localparam int EXP_HOLD = $rtoi(2.0 * DST_PS / SRC_PS + 0.5);

    logic src_clk = 1'b0, dst_clk = 1'b0;
    logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic src_bit = 1'b0;
    logic src_busy, dst_bit;

    int checks = 0, fails = 0;
    bit finished = 0;
    bit exp_q[$];
    int m_cnt = 0;
    bit m_held = 0;
    bit dst_seen = 0;
    bit dst_live = 0;

    stretch_bit_cdc #(
        .SRC_PERIOD_PS (SRC_PS),
        .DST_PERIOD_PS (DST_PS),
        .SYNC_STAGES   (STAGES)
    ) u_stretch_bit_cdc (
        .src_clk    (src_clk),
        .src_rst_n  (src_rst_n),
        .src_bit_i  (src_bit),
        .src_busy_o (src_busy),
        .dst_clk    (dst_clk),
        .dst_rst_n  (dst_rst_n),
        .dst_bit_o  (dst_bit)
    );

    always #2.5 src_clk = ~src_clk;

    initial begin
        real ph;
        ph = $urandom_range(0, 1369) / 100.0;
        #(ph);
        forever #6.85 dst_clk = ~dst_clk;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One source cycle: advance the model at the edge, compare busy, then drive v.
    task automatic src_step(input bit v);
        @(posedge src_clk);
        if (m_cnt == 0 && src_bit != m_held) begin
            m_held = src_bit;
            m_cnt  = EXP_HOLD - 1;
            exp_q.push_back(src_bit);
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        @(negedge src_clk);
        check(src_busy == (m_cnt != 0), "R2/R3/R4/R5 busy", src_busy, (m_cnt != 0));
        src_bit = v;
    endtask

    // Destination monitor: every output transition must match the next taken value.
    always @(negedge dst_clk) begin
        bit e;
        if (dst_live && dst_bit !== dst_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 extra transition", dst_bit, dst_seen);
            end else begin
                e = exp_q.pop_front();
                check(dst_bit == e, "R4/R6 order", dst_bit, e);
            end
            dst_seen = dst_bit;
        end
    end

    initial begin
        int busy_cycles;
        src_bit = 1'b0;
        repeat (4) @(negedge src_clk);
        repeat (3) @(negedge dst_clk);
        @(negedge src_clk);
        check(src_busy == 1'b0, "R7 busy in reset", src_busy, 0);
        @(negedge dst_clk);
        check(dst_bit == 1'b0, "R8 output in reset", dst_bit, 0);
        dst_rst_n = 1'b1;
        @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_live  = 1;
        src_step(1'b0);
        check(src_busy == 1'b0, "R7 idle after reset", src_busy, 0);

        // R1: one toggle from idle, count the busy cycles.
        src_step(1'b1);
        busy_cycles = 0;
        for (int k = 0; k < EXP_HOLD + 3; k++) begin
            src_step(1'b1);
            if (src_busy) busy_cycles++;
        end
        check(busy_cycles == EXP_HOLD - 1, "R1 hold length", busy_cycles + 1, EXP_HOLD);

        // R5: input equal to held value keeps the source idle.
        for (int k = 0; k < 10; k++) begin
            src_step(1'b1);
            check(src_busy == 1'b0, "R5 no hold on equal input", src_busy, 0);
        end

        // Toggle every cycle: most changes land while busy, one on each expiry.
        for (int k = 0; k < 200; k++) src_step(~src_bit);

        // Random stream.
        for (int k = 0; k < 400; k++) src_step(1'($urandom_range(0, 1)));

        // Slow toggles.
        for (int k = 0; k < 20; k++) begin
            src_step(~src_bit);
            for (int j = 0; j < 6; j++) src_step(src_bit);
        end

        // Toggle exactly once per hold length, meeting each expiry edge.
        for (int k = 0; k < 30; k++) begin
            src_step(~src_bit);
            for (int j = 1; j < EXP_HOLD; j++) src_step(src_bit);
        end

        // Drain.
        for (int k = 0; k < 20; k++) src_step(src_bit);
        repeat (STAGES + 6) @(negedge dst_clk);
        check(exp_q.size() == 0, "R6 all values delivered", exp_q.size(), 0);
        check(dst_bit == m_held, "R6 final value", dst_bit, m_held);

        finished = 1;
        report();
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule